// File: doc/BRIEF.md
# Pipeline Hazard Detection and Forwarding Unit

This unit is the hazard control logic for a five-stage in-order pipeline with fetch, decode, execute, memory and write-back stages. Instruction and data memories are separate. The unit reads the register specifiers and control bits held in the decode/execute, execute/memory and memory/writeback pipeline registers. From these it decides four things: where each ALU operand comes from, whether a register read in decode must take the value being written back in the same cycle, whether the front of the pipeline must wait behind a load, and whether a branch resolved in decode must discard the instruction fetched after it.

The unit is purely combinational. The surrounding datapath applies its outputs at the next clock edge. A stall holds the program counter and the fetch/decode register, and turns the decode/execute register into a bubble. Branches are predicted not taken. A taken branch is detected in decode by comparing its two operands after the write-back bypass. It costs one cycle, because the fetch/decode register is cleared to a no-op.

Top module: `hazard_unit`

## Requirements
- R1: When the execute/memory stage writes a non-zero register equal to an execute-stage source, that operand select is 2'b10.
- R2: When only the memory/writeback stage writes a non-zero register equal to an execute-stage source, that operand select is 2'b01. With no match the select is 2'b00, which means the register file value.
- R3: When both later stages match the same execute-stage source, the execute/memory result wins and the select is 2'b10.
- R4: Register 0, or a producer whose write enable is low, never causes forwarding, bypass or a stall.
- R5: When write-back writes a non-zero register that decode reads in the same cycle, the bypass flag for that port is 1. The decode operand output then equals the write-back data. Otherwise the operand equals the register file read data.
- R6: A load in execute whose destination matches a source used by the decode instruction raises pc_hold, ifid_hold and idex_bubble, all three together.
- R7: No stall is raised when the matching decode source is not used, or when the execute-stage producer is not a load.
- R8: A branch in decode whose two operands, after bypass, are equal and that is not stalled raises branch_taken and ifid_flush.
- R9: A branch with unequal operands, or a non-branch instruction, raises neither branch_taken nor ifid_flush.
- R10: When a branch in decode is stalled by a load-use dependence, it is not resolved: branch_taken and ifid_flush stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs1 | input | AW | First source register of the decode instruction |
| id_rs2 | input | AW | Second source register of the decode instruction |
| id_use1 | input | 1 | Decode instruction reads its first source |
| id_use2 | input | 1 | Decode instruction reads its second source |
| id_branch | input | 1 | Decode instruction is a branch-if-equal |
| rf_rdata1 | input | DW | Register file read data, port 1 |
| rf_rdata2 | input | DW | Register file read data, port 2 |
| ex_rs1 | input | AW | First source of the execute-stage instruction |
| ex_rs2 | input | AW | Second source of the execute-stage instruction |
| ex_rd | input | AW | Destination of the execute-stage instruction |
| ex_regwrite | input | 1 | Execute-stage instruction writes a register |
| ex_memread | input | 1 | Execute-stage instruction is a load |
| mem_rd | input | AW | Destination of the execute/memory register |
| mem_regwrite | input | 1 | Execute/memory instruction writes a register |
| wb_rd | input | AW | Destination of the memory/writeback register |
| wb_regwrite | input | 1 | Memory/writeback instruction writes a register |
| wb_wdata | input | DW | Data being written back this cycle |
| fwd_a | output | 2 | ALU operand A source select |
| fwd_b | output | 2 | ALU operand B source select |
| byp_a | output | 1 | Decode port 1 takes write-back data |
| byp_b | output | 1 | Decode port 2 takes write-back data |
| id_opa | output | DW | Decode operand 1 after bypass |
| id_opb | output | DW | Decode operand 2 after bypass |
| pc_hold | output | 1 | Keep the program counter |
| ifid_hold | output | 1 | Keep the fetch/decode register |
| idex_bubble | output | 1 | Clear register-write and memory-write controls entering execute |
| branch_taken | output | 1 | Branch in decode resolves taken |
| ifid_flush | output | 1 | Turn the fetch/decode register into a no-op |

## Verification
The bench goes after the cases where two producers match one source. A design with the priority reversed would feed the older memory/writeback value to the ALU. It also targets destination register 0 with its write enable high. A design that forgets the zero check would forward garbage, or stall with no reason. It targets a load whose destination matches only an unused source field, which a careless design turns into a wasted stall cycle. Finally it targets a branch whose operands are equal only after the write-back bypass, and a branch that is stalled in the same cycle. A design that got those wrong would resolve the branch on a stale value, or flush an instruction while the pipeline is held.

// File: rtl/hazard_unit.sv
module hazard_unit #(
  parameter int AW = 5,
  parameter int DW = 32
) (
  input  logic [AW-1:0] id_rs1,
  input  logic [AW-1:0] id_rs2,
  input  logic          id_use1,
  input  logic          id_use2,
  input  logic          id_branch,
  input  logic [DW-1:0] rf_rdata1,
  input  logic [DW-1:0] rf_rdata2,
  input  logic [AW-1:0] ex_rs1,
  input  logic [AW-1:0] ex_rs2,
  input  logic [AW-1:0] ex_rd,
  input  logic          ex_regwrite,
  input  logic          ex_memread,
  input  logic [AW-1:0] mem_rd,
  input  logic          mem_regwrite,
  input  logic [AW-1:0] wb_rd,
  input  logic          wb_regwrite,
  input  logic [DW-1:0] wb_wdata,
  output logic [1:0]    fwd_a,
  output logic [1:0]    fwd_b,
  output logic          byp_a,
  output logic          byp_b,
  output logic [DW-1:0] id_opa,
  output logic [DW-1:0] id_opb,
  output logic          pc_hold,
  output logic          ifid_hold,
  output logic          idex_bubble,
  output logic          branch_taken,
  output logic          ifid_flush
);
  localparam logic [AW-1:0] ZERO = '0;

  logic mem_live, wb_live, ld_live, stall;

  assign mem_live = mem_regwrite && (mem_rd != ZERO);
  assign wb_live  = wb_regwrite  && (wb_rd  != ZERO);
  assign ld_live  = ex_memread && ex_regwrite && (ex_rd != ZERO);

  function automatic logic [1:0] pick(input logic [AW-1:0] src);
    if (mem_live && mem_rd == src)     return 2'b10;
    else if (wb_live && wb_rd == src)  return 2'b01;
    else                               return 2'b00;
  endfunction

  assign fwd_a = pick(ex_rs1);
  assign fwd_b = pick(ex_rs2);

  assign byp_a  = wb_live && (wb_rd == id_rs1);
  assign byp_b  = wb_live && (wb_rd == id_rs2);
  assign id_opa = byp_a ? wb_wdata : rf_rdata1;
  assign id_opb = byp_b ? wb_wdata : rf_rdata2;

  assign stall = ld_live && ((id_use1 && ex_rd == id_rs1) ||
                             (id_use2 && ex_rd == id_rs2));

  assign pc_hold     = stall;
  assign ifid_hold   = stall;
  assign idex_bubble = stall;

  assign branch_taken = id_branch && !stall && (id_opa == id_opb);
  assign ifid_flush   = branch_taken;
endmodule

// File: rtl/hazard_unit_chk.sv
module hazard_unit_chk #(
  parameter int AW = 5,
  parameter int DW = 32
) (
  input logic [AW-1:0] id_rs1,
  input logic [AW-1:0] ex_rs1,
  input logic [AW-1:0] ex_rs2,
  input logic [AW-1:0] mem_rd,
  input logic          mem_regwrite,
  input logic          id_branch,
  input logic [DW-1:0] wb_wdata,
  input logic [1:0]    fwd_a,
  input logic [1:0]    fwd_b,
  input logic          byp_a,
  input logic [DW-1:0] id_opa,
  input logic          pc_hold,
  input logic          ifid_hold,
  input logic          idex_bubble,
  input logic          branch_taken,
  input logic          ifid_flush
);
  always_comb begin
    if (mem_regwrite && mem_rd != '0 && mem_rd == ex_rs1)
      AST_MEM_WINS_A: assert (fwd_a == 2'b10) else $error("mem priority a"); // R3
    if (ex_rs1 == '0)
      AST_ZERO_NO_FWD_A: assert (fwd_a == 2'b00) else $error("zero fwd a"); // R4
    if (ex_rs2 == '0)
      AST_ZERO_NO_FWD_B: assert (fwd_b == 2'b00) else $error("zero fwd b"); // R4
    if (id_rs1 == '0)
      AST_ZERO_NO_BYP: assert (!byp_a) else $error("zero bypass"); // R4
    if (byp_a)
      AST_BYP_VALUE: assert (id_opa == wb_wdata) else $error("bypass value"); // R5
    AST_STALL_TOGETHER: assert (pc_hold == ifid_hold && ifid_hold == idex_bubble) else $error("stall split"); // R6
    AST_FLUSH_ONLY_BRANCH: assert (!ifid_flush || (id_branch && branch_taken)) else $error("stray flush"); // R8
    AST_NO_FLUSH_IN_STALL: assert (!(ifid_flush && pc_hold)) else $error("flush while held"); // R10
  end
endmodule

bind hazard_unit hazard_unit_chk #(.AW(AW), .DW(DW)) u_chk (
  .id_rs1(id_rs1), .ex_rs1(ex_rs1), .ex_rs2(ex_rs2), .mem_rd(mem_rd),
  .mem_regwrite(mem_regwrite), .id_branch(id_branch), .wb_wdata(wb_wdata),
  .fwd_a(fwd_a), .fwd_b(fwd_b), .byp_a(byp_a), .id_opa(id_opa),
  .pc_hold(pc_hold), .ifid_hold(ifid_hold), .idex_bubble(idex_bubble),
  .branch_taken(branch_taken), .ifid_flush(ifid_flush)
);

// File: tb/tb_hazard_unit.sv
module tb_hazard_unit;
  localparam int AW = 5;
  localparam int DW = 32;

  logic clk = 0;
  always #5 clk = ~clk;

  logic [AW-1:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd;
  logic id_use1, id_use2, id_branch, ex_regwrite, ex_memread, mem_regwrite, wb_regwrite;
  logic [DW-1:0] rf_rdata1, rf_rdata2, wb_wdata, id_opa, id_opb;
  logic [1:0] fwd_a, fwd_b;
  logic byp_a, byp_b, pc_hold, ifid_hold, idex_bubble, branch_taken, ifid_flush;

  int checks = 0, errors = 0;

  hazard_unit #(.AW(AW), .DW(DW)) dut (.*);

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Reference model: integer scoring of producers, written from the requirements.
  function automatic int src_sel(int src);
    int newest = 0;
    if (wb_regwrite && wb_rd == src && src != 0) newest = 1;
    if (mem_regwrite && mem_rd == src && src != 0) newest = 2;
    return newest;
  endfunction

  task automatic compare_all();
    int sa, sb, ea, eb, hold, taken;
    longint oa, ob;
    sa = src_sel(int'(ex_rs1));
    sb = src_sel(int'(ex_rs2));
    ea = (wb_regwrite && wb_rd != 0 && wb_rd == id_rs1) ? 1 : 0;
    eb = (wb_regwrite && wb_rd != 0 && wb_rd == id_rs2) ? 1 : 0;
    oa = ea ? wb_wdata : rf_rdata1;
    ob = eb ? wb_wdata : rf_rdata2;
    hold = 0;
    if (ex_memread && ex_regwrite && ex_rd != 0) begin
      if (id_use1 && ex_rd == id_rs1) hold = 1;
      if (id_use2 && ex_rd == id_rs2) hold = 1;
    end
    taken = (id_branch && hold == 0 && oa == ob) ? 1 : 0;
    chk("R1_R2_R3", "fwd_a", fwd_a, (sa == 2) ? 2 : (sa == 1 ? 1 : 0));
    chk("R1_R2_R3", "fwd_b", fwd_b, (sb == 2) ? 2 : (sb == 1 ? 1 : 0));
    chk("R4_R5", "byp_a", byp_a, ea);
    chk("R4_R5", "byp_b", byp_b, eb);
    chk("R5", "id_opa", id_opa, oa);
    chk("R5", "id_opb", id_opb, ob);
    chk("R6_R7", "pc_hold", pc_hold, hold);
    chk("R6_R7", "ifid_hold", ifid_hold, hold);
    chk("R6_R7", "idex_bubble", idex_bubble, hold);
    chk("R8_R9_R10", "branch_taken", branch_taken, taken);
    chk("R8_R9_R10", "ifid_flush", ifid_flush, taken);
  endtask

  task automatic idle();
    id_rs1 = 0; id_rs2 = 0; id_use1 = 0; id_use2 = 0; id_branch = 0;
    rf_rdata1 = 0; rf_rdata2 = 0; ex_rs1 = 0; ex_rs2 = 0; ex_rd = 0;
    ex_regwrite = 0; ex_memread = 0; mem_rd = 0; mem_regwrite = 0;
    wb_rd = 0; wb_regwrite = 0; wb_wdata = 0;
  endtask

  task automatic step();
    @(negedge clk);
    compare_all();
    @(posedge clk); #1;
  endtask

  initial begin
    idle();
    @(posedge clk); #1;
    // reset/idle state: nothing forwarded, held or flushed
    @(negedge clk);
    chk("R4", "idle fwd_a", fwd_a, 0);
    chk("R7", "idle pc_hold", pc_hold, 0);
    chk("R9", "idle flush", ifid_flush, 0);
    @(posedge clk); #1;

    // R1: EX/MEM match on operand A
    idle(); ex_rs1 = 3; mem_rd = 3; mem_regwrite = 1; step();
    @(negedge clk); chk("R1", "fwd_a mem", fwd_a, 2'b10); @(posedge clk); #1;
    // R2: MEM/WB only on operand B
    idle(); ex_rs2 = 4; wb_rd = 4; wb_regwrite = 1; step();
    @(negedge clk); chk("R2", "fwd_b wb", fwd_b, 2'b01); @(posedge clk); #1;
    // R3: both match
    idle(); ex_rs1 = 6; mem_rd = 6; wb_rd = 6; mem_regwrite = 1; wb_regwrite = 1;
    @(negedge clk); chk("R3", "fwd_a both", fwd_a, 2'b10); @(posedge clk); #1;
    // R4: register 0 and disabled write
    idle(); ex_rs1 = 0; mem_rd = 0; mem_regwrite = 1; ex_rs2 = 5; wb_rd = 5; wb_regwrite = 0;
    @(negedge clk); chk("R4", "fwd_a r0", fwd_a, 0); chk("R4", "fwd_b we low", fwd_b, 0); @(posedge clk); #1;
    idle(); ex_memread = 1; ex_regwrite = 1; ex_rd = 0; id_rs1 = 0; id_use1 = 1;
    @(negedge clk); chk("R4", "no stall r0", pc_hold, 0); @(posedge clk); #1;
    // R5: same-cycle write/read
    idle(); id_rs1 = 9; wb_rd = 9; wb_regwrite = 1; wb_wdata = 32'hCAFE_0001; rf_rdata1 = 32'h1111;
    @(negedge clk); chk("R5", "byp_a", byp_a, 1); chk("R5", "id_opa", id_opa, 32'hCAFE_0001); @(posedge clk); #1;
    // R6: load-use on second source
    idle(); ex_memread = 1; ex_regwrite = 1; ex_rd = 7; id_rs2 = 7; id_use2 = 1;
    @(negedge clk); chk("R6", "stall", {pc_hold, ifid_hold, idex_bubble}, 3'b111); @(posedge clk); #1;
    // R7: unused source and non-load producer
    idle(); ex_memread = 1; ex_regwrite = 1; ex_rd = 7; id_rs2 = 7; id_use2 = 0;
    @(negedge clk); chk("R7", "unused src", pc_hold, 0); @(posedge clk); #1;
    idle(); ex_memread = 0; ex_regwrite = 1; ex_rd = 7; id_rs1 = 7; id_use1 = 1;
    @(negedge clk); chk("R7", "not load", pc_hold, 0); @(posedge clk); #1;
    // R8: equal only after bypass
    idle(); id_branch = 1; id_rs1 = 2; id_rs2 = 3; rf_rdata1 = 5; rf_rdata2 = 8;
    wb_rd = 2; wb_regwrite = 1; wb_wdata = 8;
    @(negedge clk); chk("R8", "taken", branch_taken, 1); chk("R8", "flush", ifid_flush, 1); @(posedge clk); #1;
    // R9: unequal
    idle(); id_branch = 1; rf_rdata1 = 5; rf_rdata2 = 6;
    @(negedge clk); chk("R9", "not taken", ifid_flush, 0); @(posedge clk); #1;
    // R10: branch stalled by load
    idle(); id_branch = 1; id_rs1 = 4; id_use1 = 1; ex_memread = 1; ex_regwrite = 1; ex_rd = 4;
    @(negedge clk); chk("R10", "no flush in stall", ifid_flush, 0); chk("R10", "held", pc_hold, 1); @(posedge clk); #1;

    // random sweep over a narrow register range to force collisions
    for (int i = 0; i < 3000; i++) begin
      id_rs1 = $urandom_range(0, 3); id_rs2 = $urandom_range(0, 3);
      ex_rs1 = $urandom_range(0, 3); ex_rs2 = $urandom_range(0, 3);
      ex_rd = $urandom_range(0, 3); mem_rd = $urandom_range(0, 3); wb_rd = $urandom_range(0, 3);
      id_use1 = $urandom_range(0, 1); id_use2 = $urandom_range(0, 1);
      id_branch = $urandom_range(0, 1); ex_regwrite = $urandom_range(0, 1);
      ex_memread = $urandom_range(0, 1); mem_regwrite = $urandom_range(0, 1);
      wb_regwrite = $urandom_range(0, 1);
      rf_rdata1 = $urandom_range(0, 2); rf_rdata2 = $urandom_range(0, 2);
      wb_wdata = $urandom_range(0, 2);
      step();
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule